// File: doc/BRIEF.md
# Signed/Unsigned Decimal Result Formatter

This block sits between a bank of sixteen switches, a 32-bit ALU and a row of LEDs and seven-segment digits on a bring-up board. It splits the switch word into two 5-bit operands, a sign-mode bit and a 5-bit operation code. It widens both operands to 32 bits, with sign extension or zero extension, and hands them to the ALU with the code. The ALU result and flag come back in. The block then drives the LEDs and produces a decimal readout of the result.

The readout is a minus indicator plus the three lowest decimal digits (hundreds, tens, ones) of the result, as BCD. The sign-mode bit chooses how the result is read. In signed mode a negative two's-complement value is negated before conversion and the minus indicator is raised. In unsigned mode the raw 32-bit value is converted and no minus is shown. The conversion is a sequential shift-and-add-3 pass over all 32 result bits. It keeps only a 3-digit BCD window, so it yields the value modulo 1000. A pass starts by itself whenever the result or the sign mode changes. The digit outputs are updated, together with a one-cycle done pulse, only when a pass completes.

Top module: `alu_harness_front`

## Requirements
- R1: `op_code` equals `sw_word[4:0]`, registered one cycle after the switch word is presented.
- R2: Operand A is `sw_word[15:11]` and operand B is `sw_word[10:6]`, each registered one cycle later. When `sw_word[5]` is 0, bits 31..5 of each extended operand are 0. When `sw_word[5]` is 1, bits 31..5 are copies of operand bit 4.
- R3: One cycle after its inputs, `led_out[15]` equals `alu_flag` and `led_out[14:0]` equals `alu_result[14:0]`.
- R4: When `conv_done` is 1, `dig_hund`, `dig_tens` and `dig_ones` are BCD digits (each 0..9) of the converted magnitude modulo 1000.
- R5: In signed mode (`sw_word[5]`=1), a result with bit 31 set raises `neg_sign` and is converted as its two's-complement negation. 0x80000000 gives `neg_sign`=1 and digits 6,4,8. In unsigned mode `neg_sign` is 0 and the raw value is converted.
- R6: An all-ones result shows `neg_sign`=1 with digits 0,0,1 in signed mode, and `neg_sign`=0 with digits 2,9,5 in unsigned mode.
- R7: A change of `alu_result` or of `sw_word[5]` starts a new conversion. A change during a pass restarts it with the new value. `conv_done` is high for exactly one cycle per completed pass.
- R8: `neg_sign` and the digit outputs keep their previous values in every cycle where `conv_done` is 0.
- R9: While `rst` is high, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_word | input | 16 | Switch word: A[15:11], B[10:6], sign mode [5], code [4:0] |
| alu_result | input | 32 | Result from the ALU |
| alu_flag | input | 1 | Flag from the ALU |
| opa_ext | output | 32 | Extended operand A to the ALU |
| opb_ext | output | 32 | Extended operand B to the ALU |
| op_code | output | 5 | Operation code to the ALU |
| led_out | output | 16 | Flag on bit 15, result bits 14..0 below it |
| neg_sign | output | 1 | Minus indicator for the readout |
| dig_hund | output | 4 | Hundreds digit, BCD |
| dig_tens | output | 4 | Tens digit, BCD |
| dig_ones | output | 4 | Ones digit, BCD |
| conv_done | output | 1 | One-cycle pulse when new digits are valid |

## Verification
The bench builds the block with its defaults: a 32-bit result, 5-bit operands and a 16-bit switch word. This is the only width set where the all-ones case wraps to 295 and 0x80000000 gives 648, so both corners are reachable. Because the bench closes the loop as a model ALU, the 12 + (-16) case runs through the real operand extension. Random 32-bit results in both modes exercise the truncated BCD window across all magnitudes. Directed cases cover a mid-pass restart, a change of mode alone, and holding of the outputs between passes.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  typedef logic [3:0] bcd_digit_t;

  function automatic logic [3:0] add3_fix(input logic [3:0] d);
    return (d >= 4'd5) ? d + 4'd3 : d;
  endfunction
endpackage

// File: rtl/sw_decode.sv
module sw_decode #(
  parameter int SW_W   = 16,
  parameter int OPND_W = 5,
  parameter int OP_W   = 5,
  parameter int DATA_W = 32,
  parameter int LED_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SW_W-1:0]   sw_word,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_flag,
  output logic [DATA_W-1:0] opa_ext,
  output logic [DATA_W-1:0] opb_ext,
  output logic [OP_W-1:0]   op_code,
  output logic [LED_W-1:0]  led_out
);
  localparam int A_LSB    = SW_W - OPND_W;
  localparam int B_LSB    = A_LSB - OPND_W;
  localparam int MODE_BIT = B_LSB - 1;
  localparam int EXT_W    = DATA_W - OPND_W;

  logic              signed_mode;
  logic [OPND_W-1:0] a_raw, b_raw;

  assign signed_mode = sw_word[MODE_BIT];
  assign a_raw       = sw_word[SW_W-1:A_LSB];
  assign b_raw       = sw_word[A_LSB-1:B_LSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      opa_ext <= '0;
      opb_ext <= '0;
      op_code <= '0;
      led_out <= '0;
    end else begin
      opa_ext <= {{EXT_W{signed_mode & a_raw[OPND_W-1]}}, a_raw};
      opb_ext <= {{EXT_W{signed_mode & b_raw[OPND_W-1]}}, b_raw};
      op_code <= sw_word[OP_W-1:0];
      led_out <= {alu_flag, alu_result[LED_W-2:0]};
    end
  end

  AST_EXT_UPPER_A: assert property (@(posedge clk) disable iff (rst)
    (|opa_ext[DATA_W-1:OPND_W]) |-> (&opa_ext[DATA_W-1:OPND_W-1])); // R2
  AST_EXT_UPPER_B: assert property (@(posedge clk) disable iff (rst)
    (|opb_ext[DATA_W-1:OPND_W]) |-> (&opb_ext[DATA_W-1:OPND_W-1])); // R2
  AST_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
    !signed_mode |=> (opa_ext[DATA_W-1:OPND_W] == '0)); // R2
endmodule

// File: rtl/bcd_mod_conv.sv
module bcd_mod_conv
  import fmt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NDIG   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] mag_in,
  input  logic              neg_in,
  output logic [4*NDIG-1:0] dig_out,
  output logic              neg_out,
  output logic              done
);
  localparam int BCD_W = 4 * NDIG;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic [BCD_W-1:0]  bcd, fixed, bcd_next;
  logic              neg_l;

  for (genvar g = 0; g < NDIG; g++) begin : g_fix
    assign fixed[4*g +: 4] = add3_fix(bcd[4*g +: 4]);
  end

  assign bcd_next = {fixed[BCD_W-2:0], shreg[DATA_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      bcd     <= '0;
      neg_l   <= 1'b0;
      dig_out <= '0;
      neg_out <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        shreg <= mag_in;
        bcd   <= '0;
        cnt   <= '0;
        busy  <= 1'b1;
        neg_l <= neg_in;
      end else if (busy) begin
        bcd   <= bcd_next;
        shreg <= shreg << 1;
        cnt   <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy    <= 1'b0;
          dig_out <= bcd_next;
          neg_out <= neg_l;
          done    <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_HOLD_DIGITS: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(dig_out) && $stable(neg_out))); // R8

  for (genvar g = 0; g < NDIG; g++) begin : g_chk
    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (rst)
      done |-> (dig_out[4*g +: 4] <= 4'd9)); // R4
  end
endmodule

// File: rtl/alu_harness_front.sv
module alu_harness_front #(
  parameter int SW_W   = 16,
  parameter int OPND_W = 5,
  parameter int OP_W   = 5,
  parameter int DATA_W = 32,
  parameter int LED_W  = 16,
  parameter int NDIG   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SW_W-1:0]   sw_word,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_flag,
  output logic [DATA_W-1:0] opa_ext,
  output logic [DATA_W-1:0] opb_ext,
  output logic [OP_W-1:0]   op_code,
  output logic [LED_W-1:0]  led_out,
  output logic              neg_sign,
  output logic [3:0]        dig_hund,
  output logic [3:0]        dig_tens,
  output logic [3:0]        dig_ones,
  output logic              conv_done
);
  localparam int MODE_BIT = SW_W - 2 * OPND_W - 1;

  logic              mode_now, primed, last_mode, start, neg_now;
  logic [DATA_W-1:0] last_res, mag;
  logic [4*NDIG-1:0] digits;

  sw_decode #(
    .SW_W(SW_W), .OPND_W(OPND_W), .OP_W(OP_W), .DATA_W(DATA_W), .LED_W(LED_W)
  ) u_dec (
    .clk(clk), .rst(rst), .sw_word(sw_word), .alu_result(alu_result),
    .alu_flag(alu_flag), .opa_ext(opa_ext), .opb_ext(opb_ext),
    .op_code(op_code), .led_out(led_out)
  );

  assign mode_now = sw_word[MODE_BIT];
  assign neg_now  = mode_now & alu_result[DATA_W-1];
  assign mag      = neg_now ? (~alu_result + 1'b1) : alu_result;
  assign start    = !primed || (alu_result != last_res) || (mode_now != last_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      primed    <= 1'b0;
      last_res  <= '0;
      last_mode <= 1'b0;
    end else if (start) begin
      primed    <= 1'b1;
      last_res  <= alu_result;
      last_mode <= mode_now;
    end
  end

  bcd_mod_conv #(.DATA_W(DATA_W), .NDIG(NDIG)) u_conv (
    .clk(clk), .rst(rst), .start(start), .mag_in(mag), .neg_in(neg_now),
    .dig_out(digits), .neg_out(neg_sign), .done(conv_done)
  );

  assign dig_ones = digits[3:0];
  assign dig_tens = digits[7:4];
  assign dig_hund = digits[11:8];

  AST_NO_SIGN_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !last_mode) |-> !neg_sign); // R5
endmodule

// File: tb/sim_alu_harness_front.sv
module sim_alu_harness_front;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sw = '0;
  logic [31:0] res = '0;
  logic        flag = 1'b0;
  logic [31:0] opa, opb;
  logic [4:0]  opc;
  logic [15:0] led;
  logic        neg, done;
  logic [3:0]  dh, dt, d1;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  alu_harness_front u0 (
    .clk(clk), .rst(rst), .sw_word(sw), .alu_result(res), .alu_flag(flag),
    .opa_ext(opa), .opb_ext(opb), .op_code(opc), .led_out(led),
    .neg_sign(neg), .dig_hund(dh), .dig_tens(dt), .dig_ones(d1),
    .conv_done(done)
  );

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_disp(input logic [31:0] r, input logic m);
    logic        n;
    logic [31:0] mg, v;
    n  = m & r[31];
    mg = n ? (0 - r) : r;
    v  = mg % 1000;
    return {19'd0, n, 4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic logic [31:0] exp_ext(input logic [4:0] x, input logic m);
    return (m && x[4]) ? {27'h7ffffff, x} : {27'd0, x};
  endfunction

  function automatic logic [31:0] got_disp();
    return {19'd0, neg, dh, dt, d1};
  endfunction

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(done, tag, 32'(done), 32'd1);
  endtask

  task automatic convert_and_check(input logic [31:0] r, input logic m, input string tag);
    @(negedge clk);
    res = r;
    sw[5] = m;
    @(negedge clk);
    wait_done(tag);
    check(got_disp() == exp_disp(r, m), tag, got_disp(), exp_disp(r, m));
    @(negedge clk);
    check(!done, "R7 done pulse width", 32'(done), 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R9: reset state
    repeat (3) @(negedge clk);
    sw = 16'hffff; res = 32'hffffffff; flag = 1'b1;
    @(negedge clk);
    check({opa, opb, opc, led, neg, dh, dt, d1, done} == '0, "R9 reset outputs",
          {opc, led, 11'd0}, 32'd0);
    sw = '0; res = '0; flag = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    wait_done("R7 first pass after reset");
    check(got_disp() == 32'd0, "R4 zero result", got_disp(), 32'd0);

    // R1 R2 R3: random switch decode and LED mapping
    for (int i = 0; i < 24; i++) begin
      logic [15:0] s;
      logic [31:0] r;
      logic        f;
      s = 16'($urandom);
      r = $urandom;
      f = 1'($urandom);
      sw = s; res = r; flag = f;
      @(negedge clk);
      check(opc == s[4:0], "R1 op code", 32'(opc), 32'(s[4:0]));
      check(opa == exp_ext(s[15:11], s[5]), "R2 operand A", opa, exp_ext(s[15:11], s[5]));
      check(opb == exp_ext(s[10:6], s[5]), "R2 operand B", opb, exp_ext(s[10:6], s[5]));
      check(led == {f, r[14:0]}, "R3 led map", 32'(led), 32'({f, r[14:0]}));
    end
    wait_done("R7 settle");
    @(negedge clk);

    // R2 R5: 12 + (-16) through extended operands, bench acts as ALU
    sw = {5'd12, 5'b10000, 1'b1, 5'd0};
    @(negedge clk);
    res = opa + opb;
    check(res == 32'hfffffffc, "R2 signed sum path", res, 32'hfffffffc);
    @(negedge clk);
    wait_done("R5 12 plus -16");
    check(got_disp() == {19'd0, 1'b1, 12'h004}, "R5 shows -4", got_disp(), {19'd0, 1'b1, 12'h004});

    // R6: all ones in both modes (second one is a mode-only change, R7)
    convert_and_check(32'hffffffff, 1'b1, "R6 signed all ones");
    check(got_disp() == {19'd0, 1'b1, 12'h001}, "R6 signed -1", got_disp(), {19'd0, 1'b1, 12'h001});
    convert_and_check(32'hffffffff, 1'b0, "R7 mode-only change");
    check(got_disp() == {19'd0, 1'b0, 12'h295}, "R6 unsigned 295", got_disp(), {19'd0, 1'b0, 12'h295});

    // R5: most negative value
    convert_and_check(32'h80000000, 1'b1, "R5 min value");
    check(got_disp() == {19'd0, 1'b1, 12'h648}, "R5 min shows 648", got_disp(), {19'd0, 1'b1, 12'h648});
    convert_and_check(32'h80000000, 1'b0, "R5 min unsigned");
    convert_and_check(32'd999, 1'b0, "R4 999");
    convert_and_check(32'd1000, 1'b1, "R4 1000 wraps");

    // R4 R5: random results in both modes
    for (int i = 0; i < 40; i++) begin
      logic [31:0] r;
      logic        m;
      r = $urandom;
      m = 1'($urandom);
      if (r == res && m == sw[5]) r = r ^ 32'h1;
      convert_and_check(r, m, "R4 random conversion");
    end

    // R8: hold while a new pass runs
    begin
      logic [31:0] old;
      old = got_disp();
      @(negedge clk);
      res = 32'd123456;
      sw[5] = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        check(!done && got_disp() == old, "R8 hold before done", got_disp(), old);
      end
      wait_done("R8 new pass ends");
      check(got_disp() == exp_disp(32'd123456, 1'b0), "R8 new digits",
            got_disp(), exp_disp(32'd123456, 1'b0));
    end

    // R7: change mid-pass restarts with the new value
    @(negedge clk);
    res = 32'd777001;
    repeat (12) @(negedge clk);
    check(!done, "R7 no done mid pass", 32'(done), 32'd0);
    res = 32'hfffffe0c;
    sw[5] = 1'b1;
    @(negedge clk);
    wait_done("R7 restart completes");
    check(got_disp() == exp_disp(32'hfffffe0c, 1'b1), "R7 restart value",
          got_disp(), exp_disp(32'hfffffe0c, 1'b1));

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule